// File: doc/BRIEF.md
# Bit-Plane Dot-Product Recombiner with Affine Scaling

This block sits behind the column converters of an in-memory matrix-vector array that works one input bit-plane at a time. Every array column returns an 8-bit conversion code per bit-plane. The bits of one matrix element lie in neighbouring columns. The bits of the input vector arrive one plane per beat, least significant plane first. The block picks the group of columns that holds one matrix element, gives each column the weight of its matrix bit and each beat the weight of its input bit, and sums the terms into a wide accumulator. The result is one multi-bit dot product.

Once the last plane has been summed, the accumulator goes through a fixed affine chain: a per-column multiplier and right shift, a per-column offset, a global left shift and a global offset. The chain saturates to a signed 32-bit word. An optional rectifier then clamps negative results to zero. The result word is held under a valid/ready handshake, and a one-cycle done strobe marks the moment it first appears.

Top module: `bitplane_accum_scale`

## Requirements
- R1: After reset, outValid and done are 0 and result is 0.
- R2: With cfgXnor=0 and cfgSigned=0, the dot product is the sum over planes i and lanes j of code(plane i, column cfgColBase+j) times 2^(i+j). The matrix precision is cfgBitsA+1 and the input precision is cfgBitsX+1, each from 1 to 8. Plane 0 is the first beat.
- R3: With cfgSigned=1, a term whose lane is the top matrix bit or whose plane is the top input bit is subtracted. A term that is both is added.
- R4: With cfgXnor=1, each code c is first mapped to the signed value 2c - cfgRowCount.
- R5: Only the columns cfgColBase to cfgColBase+cfgBitsA take part. Lanes whose column index is NUM_COLS or above contribute zero.
- R6: result = ((((acc * cfgLocalScale) >>> cfgLocalExp) + cfgLocalOffset) <<< cfgGlobalExp) + cfgGlobalOffset. The scale is unsigned 9-bit, the local offset is signed 11-bit and the global offset is signed 32-bit.
- R7: A value above 2^31-1 gives 32'h7FFFFFFF, and a value below -2^31 gives 32'h80000000.
- R8: With cfgRelu=1, a negative saturated value gives 0.
- R9: A beat is taken only on a cycle where adcValid=1 and the block is accumulating. outValid rises, with done high for exactly that one cycle, one cycle after the clock edge that takes the last beat.
- R10: While outValid=1 and outReady=0, result and outValid hold and start is ignored. outValid drops on the cycle after acceptance.
- R11: An adcValid beat that arrives after the last plane has been taken, or while idle or holding, does not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new dot product when idle |
| adcValid | input | 1 | A bit-plane of column codes is present |
| adcCodes | input | NUM_COLS*8 | Column codes; column k occupies bits 8k+7:8k |
| cfgColBase | input | clog2(NUM_COLS) | First column of the matrix-bit group |
| cfgBitsA | input | 3 | Matrix precision minus one |
| cfgBitsX | input | 3 | Input precision minus one |
| cfgXnor | input | 1 | 1: map codes as +/-1 products |
| cfgSigned | input | 1 | 1: top bits of both operands carry negative weight |
| cfgRowCount | input | ROW_W | Active row count used by the +/-1 mapping |
| cfgLocalScale | input | 9 | Unsigned column multiplier |
| cfgLocalExp | input | LEXP_W | Right shift after the multiply |
| cfgLocalOffset | input | 11 | Signed column offset |
| cfgGlobalExp | input | GEXP_W | Left shift applied to the column result |
| cfgGlobalOffset | input | 32 | Signed global offset |
| cfgRelu | input | 1 | 1: clamp negative results to zero |
| outReady | input | 1 | Consumer accepts the result |
| outValid | output | 1 | Result available |
| done | output | 1 | One-cycle strobe when a new result appears |
| result | output | 32 | Final signed result |

## Verification
On every cycle, the assertions check the handshake: done pairs with a freshly risen outValid and lasts one cycle, result and outValid hold under back-pressure, outValid drops after acceptance, and an enabled rectifier never lets a negative word out. The arithmetic is shown only by the bench scenarios, which compare results with an independent model. These are the weighting and subtraction of the top bits, the +/-1 code mapping, column groups that run off the array edge, the affine chain, and saturation at both limits. The scenarios also show that idle-gap beats, surplus beats and start pulses during a hold leave the result unchanged.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  localparam int MAX_BITS = 8;
  localparam int PLANE_W  = $clog2(MAX_BITS);
  localparam int CODE_W   = 8;

  typedef struct packed {
    logic               clrAcc;
    logic               accEn;
    logic [PLANE_W-1:0] plane;
    logic               loadRes;
  } strobe_t;
endpackage

// File: rtl/bpa_colmux.sv
module bpa_colmux
  import bpa_pkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int ROW_W    = 12,
  parameter int VAL_W    = ROW_W + 2,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int IDX_W   = COL_W + 4
) (
  input  logic [NUM_COLS*CODE_W-1:0]      adcCodes,
  input  logic [COL_W-1:0]                colBase,
  input  logic [PLANE_W-1:0]              bitsA,
  input  logic                            xnorMode,
  input  logic [ROW_W-1:0]                rowCount,
  output logic [MAX_BITS-1:0][VAL_W-1:0]  laneVal
);
  logic [CODE_W-1:0] codeArr [NUM_COLS];

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_unpack
    assign codeArr[c] = adcCodes[c*CODE_W +: CODE_W];
  end

  for (genvar lane = 0; lane < MAX_BITS; lane++) begin : g_lane
    logic [IDX_W-1:0]        idx;
    logic                    inUse;
    logic [CODE_W-1:0]       code;
    logic signed [VAL_W-1:0] twice;
    logic signed [VAL_W-1:0] rows;

    assign idx   = IDX_W'(colBase) + IDX_W'(lane);
    assign inUse = (PLANE_W'(lane) <= bitsA) && (idx < IDX_W'(NUM_COLS));
    assign code  = inUse ? codeArr[idx[COL_W-1:0]] : '0;
    assign twice = VAL_W'({code, 1'b0});
    assign rows  = VAL_W'(rowCount);

    always_comb begin
      if (!inUse)        laneVal[lane] = '0;
      else if (xnorMode) laneVal[lane] = twice - rows;
      else               laneVal[lane] = VAL_W'(code);
    end
  end
endmodule

// File: rtl/bpa_datapath.sv
module bpa_datapath
  import bpa_pkg::*;
#(
  parameter int VAL_W  = 14,
  parameter int ACC_W  = 40,
  parameter int LEXP_W = 5,
  parameter int GEXP_W = 4,
  localparam int PART_W = VAL_W + MAX_BITS + 1,
  localparam int PROD_W = ACC_W + 10,
  localparam int WIDE_W = PROD_W + (1 << GEXP_W) + 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        st,
  input  logic [MAX_BITS-1:0][VAL_W-1:0] laneVal,
  input  logic [PLANE_W-1:0]             bitsA,
  input  logic [PLANE_W-1:0]             bitsX,
  input  logic                           signedMode,
  input  logic                           relu,
  input  logic [8:0]                     localScale,
  input  logic [LEXP_W-1:0]              localExp,
  input  logic [10:0]                    localOffset,
  input  logic [GEXP_W-1:0]              globalExp,
  input  logic [31:0]                    globalOffset,
  output logic [31:0]                    result
);
  logic signed [PART_W-1:0] partial;
  logic signed [ACC_W-1:0]  term;
  logic signed [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prod;
  logic signed [WIDE_W-1:0] wide;
  logic                     negPlane;
  logic                     posOv;
  logic                     negOv;
  logic [31:0]              sat32;
  logic [31:0]              finalVal;

  // weighted sum across matrix-bit lanes of one plane
  always_comb begin
    partial = '0;
    for (int j = 0; j < MAX_BITS; j++) begin
      logic signed [PART_W-1:0] shifted;
      shifted = PART_W'(signed'(laneVal[j])) <<< j;
      if (signedMode && (PLANE_W'(j) == bitsA)) partial = partial - shifted;
      else                                      partial = partial + shifted;
    end
  end

  assign negPlane = signedMode && (st.plane == bitsX);
  assign term     = ACC_W'(partial) <<< st.plane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          acc <= '0;
    else if (st.clrAcc) acc <= '0;
    else if (st.accEn)  acc <= negPlane ? acc - term : acc + term;
  end

  // affine chain
  always_comb begin
    prod = PROD_W'(acc) * PROD_W'(signed'({1'b0, localScale}));
    wide = WIDE_W'(prod >>> localExp);
    wide = wide + WIDE_W'(signed'(localOffset));
    wide = wide <<< globalExp;
    wide = wide + WIDE_W'(signed'(globalOffset));
  end

  assign posOv    = !wide[WIDE_W-1] && (|wide[WIDE_W-2:31]);
  assign negOv    =  wide[WIDE_W-1] && !(&wide[WIDE_W-2:31]);
  assign sat32    = posOv ? 32'h7FFF_FFFF : (negOv ? 32'h8000_0000 : wide[31:0]);
  assign finalVal = (relu && sat32[31]) ? 32'h0 : sat32;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           result <= '0;
    else if (st.loadRes) result <= finalVal;
  end
endmodule

// File: rtl/bpa_ctrl.sv
module bpa_ctrl
  import bpa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               adcValid,
  input  logic               outReady,
  input  logic [PLANE_W-1:0] bitsX,
  output strobe_t            st,
  output logic               outValid,
  output logic               done
);
  typedef enum logic [1:0] {S_IDLE, S_ACCUM, S_SCALE, S_HOLD} state_t;

  state_t             state;
  logic [PLANE_W-1:0] plane;

  always_comb begin
    st.clrAcc  = (state == S_IDLE) && start;
    st.accEn   = (state == S_ACCUM) && adcValid;
    st.plane   = plane;
    st.loadRes = (state == S_SCALE);
  end

  assign outValid = (state == S_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      plane <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == S_SCALE);
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_ACCUM;
          plane <= '0;
        end
        S_ACCUM: if (adcValid) begin
          if (plane == bitsX) state <= S_SCALE;
          else                plane <= plane + 1'b1;
        end
        S_SCALE: state <= S_HOLD;
        S_HOLD:  if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitplane_accum_scale.sv
module bitplane_accum_scale
  import bpa_pkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int ROW_W    = 12,
  parameter int ACC_W    = 40,
  parameter int LEXP_W   = 5,
  parameter int GEXP_W   = 4,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int VAL_W   = ROW_W + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       adcValid,
  input  logic [NUM_COLS*CODE_W-1:0] adcCodes,
  input  logic [COL_W-1:0]           cfgColBase,
  input  logic [PLANE_W-1:0]         cfgBitsA,
  input  logic [PLANE_W-1:0]         cfgBitsX,
  input  logic                       cfgXnor,
  input  logic                       cfgSigned,
  input  logic [ROW_W-1:0]           cfgRowCount,
  input  logic [8:0]                 cfgLocalScale,
  input  logic [LEXP_W-1:0]          cfgLocalExp,
  input  logic [10:0]                cfgLocalOffset,
  input  logic [GEXP_W-1:0]          cfgGlobalExp,
  input  logic [31:0]                cfgGlobalOffset,
  input  logic                       cfgRelu,
  input  logic                       outReady,
  output logic                       outValid,
  output logic                       done,
  output logic [31:0]                result
);
  strobe_t                        st;
  logic [MAX_BITS-1:0][VAL_W-1:0] laneVal;

  bpa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .adcValid(adcValid),
    .outReady(outReady), .bitsX(cfgBitsX), .st(st),
    .outValid(outValid), .done(done)
  );

  bpa_colmux #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .VAL_W(VAL_W)) u_colmux (
    .adcCodes(adcCodes), .colBase(cfgColBase), .bitsA(cfgBitsA),
    .xnorMode(cfgXnor), .rowCount(cfgRowCount), .laneVal(laneVal)
  );

  bpa_datapath #(.VAL_W(VAL_W), .ACC_W(ACC_W), .LEXP_W(LEXP_W), .GEXP_W(GEXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .laneVal(laneVal),
    .bitsA(cfgBitsA), .bitsX(cfgBitsX), .signedMode(cfgSigned), .relu(cfgRelu),
    .localScale(cfgLocalScale), .localExp(cfgLocalExp), .localOffset(cfgLocalOffset),
    .globalExp(cfgGlobalExp), .globalOffset(cfgGlobalOffset), .result(result)
  );
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker (
  input logic        clk,
  input logic        rstN,
  input logic        outValid,
  input logic        outReady,
  input logic        done,
  input logic        cfgRelu,
  input logic [31:0] result
);
  p_done_fresh_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outValid && !$past(outValid)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(result)));

  p_drop_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid);

  p_relu_nonneg_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgRelu) |-> !result[31]);
endmodule

bind bitplane_accum_scale bpa_checker u_bpa_checker (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .done(done), .cfgRelu(cfgRelu), .result(result)
);

// File: tb/bitplane_accum_scale_bench.sv
module bitplane_accum_scale_bench;
  localparam int NUM_COLS = 16;
  localparam int ROW_W    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                  start = 0, adcValid = 0, outReady = 0;
  logic [NUM_COLS*8-1:0] adcCodes = '0;
  logic [3:0]            cfgColBase = 0;
  logic [2:0]            cfgBitsA = 0, cfgBitsX = 0;
  logic                  cfgXnor = 0, cfgSigned = 0, cfgRelu = 0;
  logic [ROW_W-1:0]      cfgRowCount = 0;
  logic [8:0]            cfgLocalScale = 1;
  logic [4:0]            cfgLocalExp = 0;
  logic [10:0]           cfgLocalOffset = 0;
  logic [3:0]            cfgGlobalExp = 0;
  logic [31:0]           cfgGlobalOffset = 0;
  logic                  outValid, done;
  logic [31:0]           result;

  logic [7:0] codes [8][NUM_COLS];
  int total = 0;
  int bad = 0;

  bitplane_accum_scale u_bitplane_accum_scale (
    .clk(clk), .rstN(rstN), .start(start), .adcValid(adcValid), .adcCodes(adcCodes),
    .cfgColBase(cfgColBase), .cfgBitsA(cfgBitsA), .cfgBitsX(cfgBitsX),
    .cfgXnor(cfgXnor), .cfgSigned(cfgSigned), .cfgRowCount(cfgRowCount),
    .cfgLocalScale(cfgLocalScale), .cfgLocalExp(cfgLocalExp),
    .cfgLocalOffset(cfgLocalOffset), .cfgGlobalExp(cfgGlobalExp),
    .cfgGlobalOffset(cfgGlobalOffset), .cfgRelu(cfgRelu), .outReady(outReady),
    .outValid(outValid), .done(done), .result(result)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model();
    longint acc = 0;
    logic signed [127:0] w;
    for (int i = 0; i <= int'(cfgBitsX); i++) begin
      for (int j = 0; j <= int'(cfgBitsA); j++) begin
        int col = int'(cfgColBase) + j;
        if (col < NUM_COLS) begin
          longint v = cfgXnor ? 2 * longint'(codes[i][col]) - longint'(cfgRowCount)
                              : longint'(codes[i][col]);
          longint t = v * (longint'(1) << (i + j));
          bit neg = cfgSigned && ((i == int'(cfgBitsX)) != (j == int'(cfgBitsA)));
          acc += neg ? -t : t;
        end
      end
    end
    w = 128'(signed'(acc));
    w = w * 128'(cfgLocalScale);
    w = w >>> cfgLocalExp;
    w = w + 128'(signed'(cfgLocalOffset));
    w = w <<< cfgGlobalExp;
    w = w + 128'(signed'(cfgGlobalOffset));
    if (w > 128'sd2147483647)       model = 32'h7FFF_FFFF;
    else if (w < -128'sd2147483648) model = 32'h8000_0000;
    else                            model = w[31:0];
    if (cfgRelu && model[31]) model = 32'h0;
  endfunction

  function automatic logic [NUM_COLS*8-1:0] packPlane(input int p);
    for (int c = 0; c < NUM_COLS; c++) packPlane[c*8 +: 8] = codes[p][c];
  endfunction

  task automatic fillRandom();
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < NUM_COLS; c++) codes[p][c] = 8'($urandom_range(0, 255));
  endtask

  task automatic unityPost();
    cfgLocalScale = 1; cfgLocalExp = 0; cfgLocalOffset = 0;
    cfgGlobalExp = 0; cfgGlobalOffset = 0; cfgRelu = 0;
  endtask

  // one full operation; returns the accepted result
  task automatic runOp(input string tag, input bit extra, input int stall, input int gap,
                       output logic [31:0] got);
    logic [31:0] exp;
    exp = model();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i <= int'(cfgBitsX); i++) begin
      if (i == 1) begin
        for (int g = 0; g < gap; g++) begin  // idle beats are not counted (R9)
          adcValid = 0; adcCodes = {NUM_COLS{8'h5A}};
          @(negedge clk);
        end
      end
      adcValid = 1; adcCodes = packPlane(i);
      @(negedge clk);
    end
    check({tag, " R9 no early valid"}, {31'b0, outValid}, 32'd0);
    if (extra) begin adcValid = 1; adcCodes = {NUM_COLS{8'hA5}}; end  // surplus beat, R11
    else adcValid = 0;
    @(negedge clk); adcValid = 0;
    check({tag, " R9 valid+done"}, {30'b0, outValid, done}, 32'd3);
    check({tag, " result"}, result, exp);
    got = result;
    for (int s = 0; s < stall; s++) begin
      start = (s == 0); adcValid = (s == 1);
      @(negedge clk); start = 0; adcValid = 0;
      check({tag, " R10 hold"}, {30'b0, done, outValid}, 32'd1);
      check({tag, " R10 stable"}, result, got);
    end
    outReady = 1;
    @(negedge clk); outReady = 0;
    check({tag, " R10 accept"}, {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd2024));
    for (int p = 0; p < 8; p++) for (int c = 0; c < NUM_COLS; c++) codes[p][c] = 0;

    repeat (3) @(negedge clk);
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 result", result, 32'd0);
    rstN = 1;

    // R2: full precision, all codes at maximum
    for (int p = 0; p < 8; p++) for (int c = 0; c < NUM_COLS; c++) codes[p][c] = 8'hFF;
    cfgBitsA = 7; cfgBitsX = 7; cfgColBase = 0; unityPost();
    runOp("R2 max", 0, 0, 0, got);
    check("R2 max const", got, 32'd16581375);

    // R3: signed 2x2 -> 3 - 10 - 14 + 8 = -13
    codes[0][0] = 3; codes[0][1] = 5; codes[1][0] = 7; codes[1][1] = 2;
    cfgBitsA = 1; cfgBitsX = 1; cfgSigned = 1;
    runOp("R3 signed", 0, 2, 1, got);
    check("R3 const", got, 32'hFFFF_FFF3);

    // R8: rectifier clamps the same negative value
    cfgRelu = 1;
    runOp("R8 relu", 0, 0, 0, got);
    check("R8 const", got, 32'd0);
    cfgRelu = 0;

    // R7 low: -13 + most negative offset
    cfgGlobalOffset = 32'h8000_0000;
    runOp("R7 low", 0, 0, 0, got);
    check("R7 low const", got, 32'h8000_0000);
    cfgSigned = 0; unityPost();

    // R4: +/-1 mapping, 2*100 - 300 = -100
    codes[0][0] = 100; cfgBitsA = 0; cfgBitsX = 0; cfgXnor = 1; cfgRowCount = 300;
    runOp("R4 xnor", 1, 0, 0, got);
    check("R4 const", got, 32'hFFFF_FF9C);
    cfgXnor = 0;

    // R5: group runs off the edge; only columns 12..15 count
    for (int c = 0; c < NUM_COLS; c++) codes[0][c] = (c >= 12) ? 8'd1 : 8'hFF;
    cfgColBase = 12; cfgBitsA = 7; cfgBitsX = 0;
    runOp("R5 edge", 1, 1, 0, got);
    check("R5 const", got, 32'd15);

    // R6: ((15*3)>>>1 - 5) <<< 2 + 100 = 168
    cfgLocalScale = 3; cfgLocalExp = 1; cfgLocalOffset = -11'sd5;
    cfgGlobalExp = 2; cfgGlobalOffset = 100;
    runOp("R6 chain", 0, 0, 0, got);
    check("R6 const", got, 32'd168);

    // R7 high: large product pushed by the global shift
    for (int p = 0; p < 8; p++) for (int c = 0; c < NUM_COLS; c++) codes[p][c] = 8'hFF;
    cfgColBase = 0; cfgBitsA = 7; cfgBitsX = 7;
    cfgLocalScale = 511; cfgLocalExp = 0; cfgLocalOffset = 0; cfgGlobalExp = 15; cfgGlobalOffset = 0;
    runOp("R7 high", 0, 0, 0, got);
    check("R7 high const", got, 32'h7FFF_FFFF);

    // R6/R2/R3/R4 mixed random operations against the model
    for (int n = 0; n < 40; n++) begin
      fillRandom();
      cfgColBase      = 4'($urandom_range(0, 15));
      cfgBitsA        = 3'($urandom_range(0, 7));
      cfgBitsX        = 3'($urandom_range(0, 7));
      cfgXnor         = 1'($urandom_range(0, 1));
      cfgSigned       = 1'($urandom_range(0, 1));
      cfgRelu         = 1'($urandom_range(0, 1));
      cfgRowCount     = ROW_W'($urandom_range(1, 4095));
      cfgLocalScale   = 9'($urandom_range(0, 511));
      cfgLocalExp     = 5'($urandom_range(0, 12));
      cfgLocalOffset  = 11'($urandom);
      cfgGlobalExp    = 4'($urandom_range(0, 3));
      cfgGlobalOffset = ($urandom_range(0, 3) == 0) ? $urandom : 32'(signed'(16'($urandom)));
      runOp("R6 random", 1'($urandom_range(0, 1)), $urandom_range(0, 2), $urandom_range(0, 2), got);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule